// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a synchronous static memory whose bus never needs an idle cycle between a read and a write. Each access is split into two phases. The address and control inputs are captured on one enabled rising edge. The data for that access moves on the following enabled edge. Write data is therefore taken one cycle late, and read data flows straight from the array to the output port with no output register. Accesses of either type can alternate on every cycle.

Each word holds four 9-bit bytes, and each byte has its own active-low write enable. A two-bit burst counter lets one loaded address serve four consecutive words. It steps in linear or interleaved order and wraps around indefinitely. A global clock enable freezes the whole pipeline. Three chip-select inputs can end an access. An asynchronous output enable can force the bus to high impedance at any time. The bidirectional data bus is modelled as separate `wdata`, `rdata` and `rdata_oe` signals, and the depth is a parameter.

Top module: `zbt_sram`

## Requirements
- R1: A load read (`burst_adv`=0, `is_read`=1, chip selected) captured on an enabled edge makes `rdata` show the word at `addr` during the following cycle. In that cycle `rdata_oe` is 1 while `out_en_n` is 0.
- R2: For a load write (`is_read`=0), the word on `wdata` at the next enabled edge is written to the loaded address. Byte lane i is bits [9i+8:9i] and is written only when `byte_we_n[i]` is 0. A read loaded in the very next cycle to the same address returns the new bytes. Reads and writes may alternate with no idle cycle.
- R3: With `burst_adv`=1 during an active burst, `addr`, `is_read` and `byte_we_n` are not used for the address or type. The access keeps the type it was loaded with and changes only the two low address bits. After the fourth word the burst returns to the starting word and continues.
- R4: With `order_xor`=0 the low two address bits of burst step k are (start + k) mod 4.
- R5: With `order_xor`=1 the low two address bits of burst step k are start XOR k.
- R6: The chip is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. A load with any select false starts a deselect: the burst stops, `rdata_oe` is 0 in the next cycle, and a write whose data phase falls on that edge is still written.
- R7: `burst_adv`=1 with no active burst is a no-operation. `rdata_oe` stays 0 and nothing is written.
- R8: An edge with `clk_en_n`=1 is ignored. Pipeline state and the array hold, `rdata` and `rdata_oe` keep their values, and `wdata` is not written.
- R9: `byte_we_n` has no effect on read accesses. A read loaded with `byte_we_n`=0 leaves the array unchanged.
- R10: `out_en_n`=1 forces `rdata_oe` to 0 without waiting for a clock edge. `rdata_oe` is never 1 in the data phase of a write.
- R11: While and after reset (`rst_n`=0) no access is active and `rdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; 1 suspends the edge |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b_n | input | 1 | Second active-low chip select |
| sel_c | input | 1 | Active-high chip select |
| burst_adv | input | 1 | 0 loads a new address, 1 advances the burst |
| is_read | input | 1 | Access type at load: 1 read, 0 write |
| addr | input | AW | Word address, taken on loads |
| byte_we_n | input | 4 | Active-low byte write enables, lane i = bits [9i+8:9i] |
| order_xor | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| wdata | input | 36 | Write data, taken one enabled edge after the load |
| rdata | output | 36 | Flow-through read data |
| rdata_oe | output | 1 | Drive enable for `rdata` (0 means high impedance) |

## Verification
The assertions assume that `order_xor` changes only together with a load, so the burst-order checks compare two steps of one burst taken under one order. They also assume that `clk_en_n`, the selects and the control inputs are stable around each rising edge. The bench meets both conditions by changing every input shortly after an edge, and `out_en_n` at mid-cycle. It sets the order input only in the same step as a load.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  // low address bits for burst step 'step' starting from 'start'
  function automatic logic [1:0] burst_low(burst_order_e ord, logic [1:0] start,
                                           logic [1:0] step);
    if (ord == ORD_XOR) return start ^ step;
    else                return start + step;
  endfunction

endpackage

// File: rtl/zbt_burst_step.sv
module zbt_burst_step
  import zbt_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             order_xor,
  input  logic [CNT_W-1:0] start_lo,
  input  logic [CNT_W-1:0] step_cnt,
  output logic [CNT_W-1:0] cur_lo
);

  burst_order_e ord;

  assign ord = burst_order_e'(order_xor);

  generate
    if (CNT_W == 2) begin : g_two_bit
      assign cur_lo = burst_low(ord, start_lo, step_cnt);
    end else begin : g_generic
      assign cur_lo = (ord == ORD_XOR) ? (start_lo ^ step_cnt) : (start_lo + step_cnt);
    end
  endgenerate

endmodule

// File: rtl/zbt_access_ctrl.sv
module zbt_access_ctrl #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en_n,
  input  logic          selected,
  input  logic          burst_adv,
  input  logic          is_read,
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] byte_we_n,
  input  logic          order_xor,
  output logic          acc_valid,
  output logic          acc_read,
  output logic [AW-1:0] acc_addr,
  output logic [NB-1:0] acc_we_n
);

  localparam int CW = 2;
  localparam int HW = AW - CW;

  logic          active_q,  active_d;
  logic          valid_q,   valid_d;
  logic          read_q,    read_d;
  logic [HW-1:0] hi_q,      hi_d;
  logic [CW-1:0] start_q,   start_d;
  logic [CW-1:0] cnt_q,     cnt_d;
  logic [NB-1:0] we_q,      we_d;
  logic [CW-1:0] acc_lo;

  always_comb begin
    active_d = active_q;
    valid_d  = valid_q;
    read_d   = read_q;
    hi_d     = hi_q;
    start_d  = start_q;
    cnt_d    = cnt_q;
    we_d     = we_q;
    if (!burst_adv) begin
      if (selected) begin
        active_d = 1'b1;
        valid_d  = 1'b1;
        read_d   = is_read;
        hi_d     = addr[AW-1:CW];
        start_d  = addr[CW-1:0];
        cnt_d    = '0;
        we_d     = is_read ? '1 : byte_we_n;
      end else begin
        active_d = 1'b0;
        valid_d  = 1'b0;
        we_d     = '1;
      end
    end else if (active_q) begin
      valid_d = 1'b1;
      cnt_d   = cnt_q + 1'b1;
      we_d    = read_q ? '1 : byte_we_n;
    end else begin
      valid_d = 1'b0;
      we_d    = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      valid_q  <= 1'b0;
      read_q   <= 1'b0;
      hi_q     <= '0;
      start_q  <= '0;
      cnt_q    <= '0;
      we_q     <= '1;
    end else if (!clk_en_n) begin
      active_q <= active_d;
      valid_q  <= valid_d;
      read_q   <= read_d;
      hi_q     <= hi_d;
      start_q  <= start_d;
      cnt_q    <= cnt_d;
      we_q     <= we_d;
    end
  end

  zbt_burst_step #(.CNT_W(CW)) i_step (
    .order_xor (order_xor),
    .start_lo  (start_q),
    .step_cnt  (cnt_q),
    .cur_lo    (acc_lo)
  );

  assign acc_valid = valid_q;
  assign acc_read  = read_q;
  assign acc_addr  = {hi_q, acc_lo};
  assign acc_we_n  = we_q;

  // R3: advancing keeps the loaded type and the upper address
  p_burst_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && burst_adv && active_q) |=>
      (valid_q && read_q == $past(read_q) && acc_addr[AW-1:CW] == $past(acc_addr[AW-1:CW])));

  // R4: linear order steps the low bits by one
  p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && burst_adv && active_q && !order_xor) |=>
      (acc_lo == $past(acc_lo) + 2'd1));

  // R5: interleaved order flips bit 0 alone or both bits
  p_xor_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && burst_adv && active_q && order_xor) |=>
      (((acc_lo ^ $past(acc_lo)) == 2'd1) || ((acc_lo ^ $past(acc_lo)) == 2'd3)));

  // R6: a load while deselected ends the access
  p_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !burst_adv && !selected) |=> (!valid_q && !active_q));

  // R7: advance with no burst is a no-operation
  p_noop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && burst_adv && !active_q) |=> (!valid_q && we_q == '1));

  // R8: a suspended edge leaves the pipeline untouched
  p_suspend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(acc_addr) && $stable(valid_q) && $stable(active_q) && $stable(we_q)));

endmodule

// File: rtl/zbt_byte_array.sv
module zbt_byte_array #(
  parameter int DEPTH = 64,
  parameter int NB    = 4,
  parameter int BW    = 9
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [NB-1:0]            we_n,
  input  logic [NB*BW-1:0]         wdata,
  output logic [NB*BW-1:0]         rdata
);

  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_lane
      logic [BW-1:0] lane_mem [DEPTH];

      always_ff @(posedge clk) begin
        if (wr_en && !we_n[gi]) begin
          lane_mem[addr] <= wdata[gi*BW +: BW];
        end
      end

      assign rdata[gi*BW +: BW] = lane_mem[addr];
    end
  endgenerate

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int DEPTH  = 64,
  parameter int NB     = 4,
  parameter int BW     = 9,
  parameter int AW     = $clog2(DEPTH),
  parameter int WORD_W = NB * BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic              sel_c,
  input  logic              burst_adv,
  input  logic              is_read,
  input  logic [AW-1:0]     addr,
  input  logic [NB-1:0]     byte_we_n,
  input  logic              order_xor,
  input  logic              out_en_n,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rdata_oe
);

  logic          selected;
  logic          acc_valid;
  logic          acc_read;
  logic [AW-1:0] acc_addr;
  logic [NB-1:0] acc_we_n;
  logic          wr_en;

  assign selected = !sel_a_n && !sel_b_n && sel_c;

  zbt_access_ctrl #(.AW(AW), .NB(NB)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en_n  (clk_en_n),
    .selected  (selected),
    .burst_adv (burst_adv),
    .is_read   (is_read),
    .addr      (addr),
    .byte_we_n (byte_we_n),
    .order_xor (order_xor),
    .acc_valid (acc_valid),
    .acc_read  (acc_read),
    .acc_addr  (acc_addr),
    .acc_we_n  (acc_we_n)
  );

  // the write commits on the enabled edge that carries its data
  assign wr_en = acc_valid && !acc_read && !clk_en_n;

  zbt_byte_array #(.DEPTH(DEPTH), .NB(NB), .BW(BW)) i_array (
    .clk   (clk),
    .wr_en (wr_en),
    .addr  (acc_addr),
    .we_n  (acc_we_n),
    .wdata (wdata),
    .rdata (rdata)
  );

  assign rdata_oe = acc_valid && acc_read && !out_en_n;

  // R11: bus released while reset is held
  always_comb begin
    if (!rst_n) p_reset_hiz_r11: assert (!rdata_oe);
  end

  // R8: suspended edge keeps the driven read data
  p_suspend_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_n && $stable(out_en_n)) |=> ($stable(rdata) && $stable(rdata_oe)));

endmodule

// File: tb/test_zbt_sram.sv
module test_zbt_sram;

  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int W     = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clk_en_n;
  logic          sel_a_n, sel_b_n, sel_c;
  logic          burst_adv;
  logic          is_read;
  logic [AW-1:0] addr;
  logic [3:0]    byte_we_n;
  logic          order_xor;
  logic          out_en_n;
  logic [W-1:0]  wdata;
  logic [W-1:0]  rdata;
  logic          rdata_oe;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  zbt_sram #(.DEPTH(DEPTH)) i_zbt_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
    .burst_adv(burst_adv), .is_read(is_read), .addr(addr),
    .byte_we_n(byte_we_n), .order_xor(order_xor), .out_en_n(out_en_n),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // sel: {sel_a_n, sel_b_n, sel_c}; 3'b001 selects the chip
  task automatic step(input logic adv, input logic rd, input logic [2:0] sel,
                      input logic [AW-1:0] a, input logic [3:0] we, input logic [W-1:0] wd);
    burst_adv = adv;
    is_read   = rd;
    {sel_a_n, sel_b_n, sel_c} = sel;
    addr      = a;
    byte_we_n = we;
    wdata     = wd;
    @(posedge clk);
    #2;
  endtask

  task automatic read_word(input string req, input logic [AW-1:0] a, input logic [W-1:0] exp);
    step(1'b0, 1'b1, 3'b001, a, 4'hF, '0);
    chk(req, {35'd0, rdata_oe}, 36'd1);
    chk(req, rdata, exp);
  endtask

  task automatic t_reset;
    chk("R11 reset oe", {35'd0, rdata_oe}, 36'd0);
  endtask

  task automatic t_write_read;
    step(1'b0, 1'b0, 3'b001, 6'd5, 4'h0, '0);
    chk("R10 write phase oe", {35'd0, rdata_oe}, 36'd0);
    step(1'b0, 1'b1, 3'b001, 6'd5, 4'h0, 36'h1_2345_6789);
    chk("R1 read oe", {35'd0, rdata_oe}, 36'd1);
    chk("R2 read after write", rdata, 36'h1_2345_6789);
    step(1'b0, 1'b0, 3'b001, 6'd6, 4'h0, '0);
    chk("R10 write after read oe", {35'd0, rdata_oe}, 36'd0);
    step(1'b0, 1'b1, 3'b001, 6'd6, 4'hF, 36'hA_BCDE_F012);
    chk("R2 alternating", rdata, 36'hA_BCDE_F012);
  endtask

  task automatic t_bytes;
    step(1'b0, 1'b0, 3'b001, 6'd8, 4'h0, '0);
    step(1'b0, 1'b0, 3'b001, 6'd8, 4'b1010, 36'hF_FFFF_FFFF);
    step(1'b0, 1'b1, 3'b001, 6'd8, 4'h0, 36'h0_0000_0000);
    // lanes 0 and 2 take zero, lanes 1 and 3 keep ones
    chk("R2 byte lanes", rdata, {9'h1FF, 9'h000, 9'h1FF, 9'h000});
    step(1'b0, 1'b1, 3'b001, 6'd8, 4'h0, 36'h5_5555_5555);
    chk("R9 read ignores byte enables", rdata, {9'h1FF, 9'h000, 9'h1FF, 9'h000});
    step(1'b0, 1'b1, 3'b001, 6'd8, 4'hF, 36'h3_3333_3333);
    chk("R9 array unchanged", rdata, {9'h1FF, 9'h000, 9'h1FF, 9'h000});
  endtask

  task automatic t_bursts;
    logic [W-1:0] w [4];
    w[0] = 36'h0_1111_0000; w[1] = 36'h0_2222_0001;
    w[2] = 36'h0_3333_0002; w[3] = 36'h0_4444_0003;
    // linear write burst from 17: 17,18,19,16
    order_xor = 1'b0;
    step(1'b0, 1'b0, 3'b001, 6'd17, 4'h0, '0);
    step(1'b1, 1'b1, 3'b001, 6'd40, 4'h0, w[0]);
    step(1'b1, 1'b1, 3'b001, 6'd41, 4'h0, w[1]);
    step(1'b1, 1'b1, 3'b001, 6'd42, 4'h0, w[2]);
    chk("R3 write burst keeps type", {35'd0, rdata_oe}, 36'd0);
    step(1'b0, 1'b1, 3'b110, 6'd0, 4'h0, w[3]);
    // interleaved read burst from 17: 17,16,19,18,17
    order_xor = 1'b1;
    step(1'b0, 1'b1, 3'b001, 6'd17, 4'hF, '0);
    chk("R5 xor step0", rdata, w[0]);
    step(1'b1, 1'b0, 3'b001, 6'd3, 4'h0, 36'hD_EAD0_0000);
    chk("R5 xor step1", rdata, w[3]);
    chk("R3 read burst keeps type", {35'd0, rdata_oe}, 36'd1);
    step(1'b1, 1'b0, 3'b001, 6'd3, 4'h0, 36'hD_EAD0_0001);
    chk("R5 xor step2", rdata, w[2]);
    step(1'b1, 1'b0, 3'b001, 6'd3, 4'h0, 36'hD_EAD0_0002);
    chk("R5 xor step3", rdata, w[1]);
    step(1'b1, 1'b0, 3'b001, 6'd3, 4'h0, 36'hD_EAD0_0003);
    chk("R3 burst wrap", rdata, w[0]);
    // linear read burst from 18: 18,19,16,17
    order_xor = 1'b0;
    step(1'b0, 1'b1, 3'b001, 6'd18, 4'hF, '0);
    chk("R4 linear step0", rdata, w[1]);
    step(1'b1, 1'b0, 3'b001, 6'd0, 4'h0, '0);
    chk("R4 linear step1", rdata, w[2]);
    step(1'b1, 1'b0, 3'b001, 6'd0, 4'h0, '0);
    chk("R4 linear step2", rdata, w[3]);
    step(1'b1, 1'b0, 3'b001, 6'd0, 4'h0, '0);
    chk("R4 linear step3", rdata, w[0]);
  endtask

  task automatic t_deselect;
    step(1'b0, 1'b0, 3'b001, 6'd30, 4'h0, '0);
    step(1'b0, 1'b1, 3'b000, 6'd31, 4'h0, 36'h7_0000_0030);
    chk("R6 deselect hiz", {35'd0, rdata_oe}, 36'd0);
    step(1'b1, 1'b0, 3'b001, 6'd31, 4'h0, 36'hE_EEEE_EEEE);
    chk("R7 noop hiz", {35'd0, rdata_oe}, 36'd0);
    read_word("R6 pending write done, R7 no write", 6'd30, 36'h7_0000_0030);
    for (int k = 0; k < 3; k++) begin
      logic [2:0] pat;
      pat = (k == 0) ? 3'b101 : (k == 1) ? 3'b011 : 3'b000;
      read_word("R1 read before deselect", 6'd30, 36'h7_0000_0030);
      step(1'b0, 1'b1, pat, 6'd30, 4'hF, '0);
      chk("R6 single select false", {35'd0, rdata_oe}, 36'd0);
    end
  endtask

  task automatic t_suspend;
    read_word("R1 read before suspend", 6'd5, 36'h1_2345_6789);
    clk_en_n = 1'b1;
    step(1'b0, 1'b1, 3'b001, 6'd6, 4'hF, '0);
    chk("R8 data held", rdata, 36'h1_2345_6789);
    chk("R8 oe held", {35'd0, rdata_oe}, 36'd1);
    clk_en_n = 1'b0;
    step(1'b0, 1'b0, 3'b001, 6'd40, 4'h0, '0);
    clk_en_n = 1'b1;
    step(1'b0, 1'b1, 3'b001, 6'd9, 4'h0, 36'h9_9999_9999);
    clk_en_n = 1'b0;
    step(1'b0, 1'b1, 3'b001, 6'd40, 4'hF, 36'h2_4680_1357);
    chk("R8 suspended edge wrote nothing", rdata, 36'h2_4680_1357);
  endtask

  task automatic t_out_en;
    read_word("R1 read before oe test", 6'd6, 36'hA_BCDE_F012);
    #3 out_en_n = 1'b1;
    #1 chk("R10 async oe off", {35'd0, rdata_oe}, 36'd0);
    out_en_n = 1'b0;
    #1 chk("R10 async oe on", {35'd0, rdata_oe}, 36'd1);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_en_n = 1'b0; sel_a_n = 1'b1; sel_b_n = 1'b1; sel_c = 1'b0;
    burst_adv = 1'b1; is_read = 1'b1; addr = '0; byte_we_n = 4'hF;
    order_xor = 1'b0; out_en_n = 1'b0; wdata = '0;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    step(1'b1, 1'b1, 3'b001, 6'd0, 4'hF, '0);
    t_reset();
    t_write_read();
    t_bytes();
    t_bursts();
    t_deselect();
    t_suspend();
    t_out_en();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule